// File: doc/BRIEF.md
# Return Address Stack

This block keeps the return addresses of nested subroutine calls and interrupts in a small private memory with its own pointer. A push strobe carries a 21-bit address to save. The control logic raises it for a call, a relative call or an interrupt acknowledge. A pop strobe hands back the most recent saved address. The control logic raises it for a plain return, a return that loads a literal, or a return from interrupt. Neither operation touches any other program-counter state.

The pointer is 5 bits wide. A pointer value of zero means the stack is empty, and no storage row sits behind it. The other 31 values each select one 21-bit row. A push first advances the pointer and then writes the row the pointer now selects. A pop first reads the row under the current pointer into a registered output and then moves the pointer back by one. A push on a full stack and a pop on an empty one each set a flag that stays set until reset. In both cases the stored state is left untouched.

Top module: `retaddr_stack`

## Requirements
- R1: The stack holds 31 addresses of 21 bits each. The pointer on ptr_o runs from 0 (empty) to 31 (full) and never leaves that range.
- R2: While rst_n is low and after it is released, ptr_o is 0, pop_addr_o is 0, and overflow_o and underflow_o are 0.
- R3: A push alone with ptr_o below 31 sets ptr_o to the old value plus one after the next rising edge. push_addr_i is stored in the row selected by that new pointer value.
- R4: A pop alone with ptr_o above 0 loads pop_addr_o, after the next rising edge, with the row under the old pointer. ptr_o drops by one at the same edge, so addresses come back in reverse order of pushing.
- R5: A push alone with ptr_o at 31 leaves the pointer and every stored row unchanged, and sets overflow_o.
- R6: A pop alone with ptr_o at 0 sets pop_addr_o to 0, keeps ptr_o at 0, and sets underflow_o.
- R7: full_o is 1 in exactly the cycles where ptr_o equals 31. It follows the pointer with no extra register.
- R8: Push and pop in the same cycle with ptr_o above 0 load pop_addr_o with the old top row. The top row is replaced by push_addr_i and ptr_o stays the same.
- R9: Push and pop in the same cycle with ptr_o at 0 behave as an underflowing pop. pop_addr_o becomes 0, underflow_o is set, nothing is stored and ptr_o stays at 0.
- R10: In a cycle with neither strobe, ptr_o and pop_addr_o keep their values.
- R11: Once set, overflow_o and underflow_o stay at 1 until the next reset, whatever strobes follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save push_addr_i on the stack |
| push_addr_i | input | 21 | Return address to save |
| pop_i | input | 1 | Retrieve the most recent address |
| pop_addr_o | output | 21 | Address delivered by the last pop, registered |
| ptr_o | output | 5 | Current stack pointer |
| full_o | output | 1 | High when all 31 rows are in use |
| overflow_o | output | 1 | Sticky: a push was refused on a full stack |
| underflow_o | output | 1 | Sticky: a pop found the stack empty |

## Verification
The bench fills all 31 rows and pushes once more. A design with an off-by-one limit would either wrap the pointer to zero or overwrite the top row, and the refused push must leave the later drain intact. It then drains the stack past empty. A design that lets the pointer wrap to 31, or that returns a stale row instead of zero, shows up on ptr_o and pop_addr_o. Simultaneous push and pop is applied on an empty, a partly filled and a full stack. Swapping the wrong row, moving the pointer, or storing into the empty slot all spoil later pops. Long mixed runs against a queue model catch errors in pointer arithmetic and in the sticky behaviour of the flags.

// File: rtl/retaddr_stack_pkg.sv
package retaddr_stack_pkg;

    localparam int unsigned RAS_ADDR_W = 21;
    localparam int unsigned RAS_PTR_W  = 5;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_SWAP,
        OP_OVER,
        OP_UNDER
    } stk_op_e;

endpackage

// File: rtl/retaddr_op_decode.sv
module retaddr_op_decode
    import retaddr_stack_pkg::*;
#(
    parameter int unsigned PTR_W = RAS_PTR_W
) (
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [PTR_W-1:0] ptr_i,
    output stk_op_e          op_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam logic [PTR_W-1:0] PTR_MAX  = '1;
    localparam logic [PTR_W-1:0] PTR_ZERO = '0;

    always_comb begin
        full_o  = (ptr_i == PTR_MAX);
        empty_o = (ptr_i == PTR_ZERO);
        op_o    = OP_IDLE;
        if (push_i && pop_i) begin
            op_o = empty_o ? OP_UNDER : OP_SWAP;
        end else if (push_i) begin
            op_o = full_o ? OP_OVER : OP_PUSH;
        end else if (pop_i) begin
            op_o = empty_o ? OP_UNDER : OP_POP;
        end
    end

endmodule

// File: rtl/retaddr_ptr_ctrl.sv
module retaddr_ptr_ctrl
    import retaddr_stack_pkg::*;
#(
    parameter int unsigned PTR_W = RAS_PTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic             load_pop_o,
    output logic             over_o,
    output logic             under_o
);

    localparam logic [PTR_W-1:0] PTR_ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             over;
        logic             under;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        wr_en_o    = 1'b0;
        wr_idx_o   = st_q.ptr;
        load_pop_o = 1'b0;
        unique case (op_i)
            OP_PUSH: begin
                st_d.ptr = st_q.ptr + PTR_ONE;
                wr_en_o  = 1'b1;
                wr_idx_o = st_q.ptr + PTR_ONE;
            end
            OP_POP: begin
                load_pop_o = 1'b1;
                st_d.ptr   = st_q.ptr - PTR_ONE;
            end
            OP_SWAP: begin
                load_pop_o = 1'b1;
                wr_en_o    = 1'b1;
                wr_idx_o   = st_q.ptr;
            end
            OP_OVER: begin
                st_d.over = 1'b1;
            end
            OP_UNDER: begin
                st_d.under = 1'b1;
                load_pop_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o   = st_q.ptr;
    assign over_o  = st_q.over;
    assign under_o = st_q.under;

endmodule

// File: rtl/retaddr_store.sv
module retaddr_store
    import retaddr_stack_pkg::*;
#(
    parameter int unsigned ADDR_W = RAS_ADDR_W,
    parameter int unsigned PTR_W  = RAS_PTR_W
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_data_o
);

    localparam int unsigned DEPTH = (1 << PTR_W) - 1;

    logic [ADDR_W-1:0] row_q [1:DEPTH];
    logic [DEPTH:1]    wr_sel;
    logic [DEPTH:1]    rd_sel;

    for (genvar g = 1; g <= DEPTH; g++) begin : g_row_sel
        assign wr_sel[g] = wr_en_i && (wr_idx_i == PTR_W'(g));
        assign rd_sel[g] = (rd_idx_i == PTR_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 1; i <= DEPTH; i++) begin
            if (wr_sel[i]) begin
                row_q[i] <= wr_data_i;
            end
        end
    end

    // Index 0 selects no row, so an empty-stack read yields zero.
    always_comb begin
        rd_data_o = '0;
        for (int i = 1; i <= DEPTH; i++) begin
            rd_data_o = rd_data_o | ({ADDR_W{rd_sel[i]}} & row_q[i]);
        end
    end

endmodule

// File: rtl/retaddr_stack.sv
module retaddr_stack
    import retaddr_stack_pkg::*;
#(
    parameter int unsigned ADDR_W = RAS_ADDR_W,
    parameter int unsigned PTR_W  = RAS_PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] pop_addr_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              full_o,
    output logic              overflow_o,
    output logic              underflow_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } pop_reg_t;

    stk_op_e           op;
    logic              empty;
    logic [PTR_W-1:0]  ptr;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic              load_pop;
    logic [ADDR_W-1:0] rd_data;
    pop_reg_t          pop_d, pop_q;

    retaddr_op_decode #(.PTR_W(PTR_W)) dec_i (
        .push_i  (push_i),
        .pop_i   (pop_i),
        .ptr_i   (ptr),
        .op_o    (op),
        .full_o  (full_o),
        .empty_o (empty)
    );

    retaddr_ptr_ctrl #(.PTR_W(PTR_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .ptr_o      (ptr),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .load_pop_o (load_pop),
        .over_o     (overflow_o),
        .under_o    (underflow_o)
    );

    retaddr_store #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) store_i (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (push_addr_i),
        .rd_idx_i  (ptr),
        .rd_data_o (rd_data)
    );

    always_comb begin
        pop_d = pop_q;
        if (load_pop) begin
            pop_d.addr = empty ? '0 : rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_q <= '0;
        end else begin
            pop_q <= pop_d;
        end
    end

    assign pop_addr_o = pop_q.addr;
    assign ptr_o      = ptr;

endmodule

// File: rtl/retaddr_stack_chk.sv
module retaddr_stack_chk #(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned PTR_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic [ADDR_W-1:0] pop_addr_o,
    input logic [PTR_W-1:0]  ptr_o,
    input logic              full_o,
    input logic              overflow_o,
    input logic              underflow_o
);

    localparam logic [PTR_W-1:0] PTR_MAX = '1;

    a_r3_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && ptr_o != PTR_MAX) |=> (ptr_o == $past(ptr_o) + 1'b1));

    a_r4_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && ptr_o != '0) |=> (ptr_o == $past(ptr_o) - 1'b1));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> (overflow_o && ptr_o == PTR_MAX));

    a_r6_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && ptr_o == '0) |=> (underflow_o && pop_addr_o == '0 && ptr_o == '0));

    a_r8_swap_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (ptr_o == $past(ptr_o)));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> ($stable(ptr_o) && $stable(pop_addr_o)));

    a_r11_over_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    a_r11_under_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> underflow_o);

endmodule

bind retaddr_stack retaddr_stack_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .pop_addr_o  (pop_addr_o),
    .ptr_o       (ptr_o),
    .full_o      (full_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
);

// File: tb/retaddr_stack_tb_top.sv
module retaddr_stack_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic [20:0] push_addr_i = '0;
    logic        pop_i = 1'b0;
    logic [20:0] pop_addr_o;
    logic [4:0]  ptr_o;
    logic        full_o;
    logic        overflow_o;
    logic        underflow_o;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    logic [20:0] m_stk[$];
    logic [20:0] m_pop = '0;
    logic        m_ovf = 1'b0;
    logic        m_unf = 1'b0;
    string       m_tag = "R2";

    always #2 clk = ~clk;

    retaddr_stack dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_addr_i (push_addr_i),
        .pop_i       (pop_i),
        .pop_addr_o  (pop_addr_o),
        .ptr_o       (ptr_o),
        .full_o      (full_o),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare every output against the queue model (called at negedge).
    task automatic compare_all();
        chk(m_tag, 32'(ptr_o), 32'(m_stk.size()));
        chk(m_tag, 32'(pop_addr_o), 32'(m_pop));
        chk("R7", 32'(full_o), 32'(m_stk.size() == 31));
        chk("R5/R11 overflow", 32'(overflow_o), 32'(m_ovf));
        chk("R6/R11 underflow", 32'(underflow_o), 32'(m_unf));
    endtask

    // Drive one cycle of strobes and advance the model to the post-edge state.
    task automatic step(input logic ps, input logic pp, input logic [20:0] a);
        int n;
        push_i      = ps;
        pop_i       = pp;
        push_addr_i = a;
        n = m_stk.size();
        if (ps && pp) begin
            if (n == 0) begin
                m_unf = 1'b1; m_pop = '0; m_tag = "R9";
            end else begin
                m_pop = m_stk[n-1]; m_stk[n-1] = a; m_tag = "R8";
            end
        end else if (ps) begin
            if (n == 31) begin
                m_ovf = 1'b1; m_tag = "R5";
            end else begin
                m_stk.push_back(a); m_tag = "R3";
            end
        end else if (pp) begin
            if (n == 0) begin
                m_unf = 1'b1; m_pop = '0; m_tag = "R6";
            end else begin
                m_pop = m_stk.pop_back(); m_tag = "R4";
            end
        end else begin
            m_tag = "R10";
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        push_i = 1'b0;
        pop_i  = 1'b0;
        m_stk.delete();
        m_pop = '0; m_ovf = 1'b0; m_unf = 1'b0; m_tag = "R2";
        repeat (3) @(negedge clk);
        compare_all();
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        do_reset();
        // R6: pop on empty stack, then R11 stickiness under idle and push
        step(1'b0, 1'b1, 21'h0);
        step(1'b0, 1'b0, 21'h0);
        step(1'b1, 1'b0, 21'h1ABCD);
        step(1'b0, 1'b1, 21'h0);
        do_reset();
        // R9: simultaneous strobes on an empty stack
        step(1'b1, 1'b1, 21'h12345);
        step(1'b0, 1'b1, 21'h0);
        do_reset();
        // R1/R3: fill all 31 rows
        for (int i = 1; i <= 31; i++) begin
            step(1'b1, 1'b0, 21'(i * 21'h0F0F1 + 3));
        end
        chk("R1 full depth", 32'(ptr_o), 32'd31);
        // R5: refused push, R8: swap at full
        step(1'b1, 1'b0, 21'h1FFFFF);
        step(1'b1, 1'b1, 21'h0AAAA);
        // R4: drain in reverse order and past empty (R6)
        for (int i = 0; i < 33; i++) begin
            step(1'b0, 1'b1, 21'h0);
        end
        chk("R1 floor", 32'(ptr_o), 32'd0);
        do_reset();
        // Mixed random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (i % 1500 == 0 && i != 0) begin
                do_reset();
            end
            if (r < 40) begin
                step(1'b1, 1'b0, 21'($urandom));
            end else if (r < 75) begin
                step(1'b0, 1'b1, 21'h0);
            end else if (r < 88) begin
                step(1'b1, 1'b1, 21'($urandom));
            end else begin
                step(1'b0, 1'b0, 21'($urandom));
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule